// File: doc/BRIEF.md
# Integer Adder with Carry and Overflow Flags

This unit is the add slice of a small processor's execute stage. Each accepted request selects one of four additions. Two take a pair of 32-bit register operands. Two take one register operand and a 16-bit immediate, which is sign-extended to 32 bits. One variant in each pair also adds the stored carry flag as a third input. The unit holds the carry and overflow flags itself. Both flags are replaced by every accepted operation and are read back at the outputs.

An overflow-exception enable input comes from the processor's status word. When it is set and an addition produces signed overflow, the unit emits a one-cycle range-exception request, which the trap logic then handles. A carry out never raises the request. The register file and exception vectoring sit outside this block.

Top module: `add_flag_unit`

## Requirements
- R1: A synchronous reset (`rst_i` high at a rising clock edge) clears `result_o`, `carry_o`, `ovf_o` and `range_exc_o` to zero.
- R2: With `op_i` = 2'b00, the next `result_o` is `opa_i + opb_i` modulo 2^32. The stored carry has no effect: 1 + 2 gives 3 even with `carry_o` set.
- R3: With `op_i` = 2'b01, the next `result_o` is `opa_i + opb_i + carry_o`, where `carry_o` is the value held before the edge.
- R4: With `op_i` = 2'b10, `imm_i` is sign-extended from bit 15 (0x8000 becomes 0xffff8000, 0xfffe becomes 0xfffffffe) and added to `opa_i`. The stored carry is ignored.
- R5: With `op_i` = 2'b11, the sign-extended `imm_i`, `opa_i` and the stored carry are summed.
- R6: `carry_o` becomes the unsigned carry out of bit 31 of the full sum, carry-in included. Example: 0xffffffff + 0 + 1 gives 0 with carry set and overflow clear, in either operand order.
- R7: `ovf_o` becomes two's-complement signed overflow of the full sum, carry-in included. A carry-in can cause overflow (0x40000000 + 0x3fffffff + 1) and can also prevent it (0xc0000000 + 0xbfffffff + 1).
- R8: When `ovf_exc_en_i` is high on an accepted edge that sets overflow, `range_exc_o` is high for exactly the following cycle. Carry alone never raises it.
- R9: When `ovf_exc_en_i` is low, `range_exc_o` stays low whatever the flags.
- R10: On an edge with `valid_i` low, `result_o`, `carry_o` and `ovf_o` hold their values and `range_exc_o` is low.
- R11: Both flags are written on every accepted operation. Earlier values are replaced, not accumulated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_i | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Accepts the operation on this edge |
| op_i | input | 2 | bit0 = add stored carry, bit1 = use immediate |
| opa_i | input | 32 | First register operand |
| opb_i | input | 32 | Second register operand |
| imm_i | input | 16 | Immediate, sign-extended before use |
| ovf_exc_en_i | input | 1 | Overflow-exception enable from the status word |
| result_o | output | 32 | Registered sum |
| carry_o | output | 1 | Stored carry flag |
| ovf_o | output | 1 | Stored overflow flag |
| range_exc_o | output | 1 | One-cycle range-exception request |

## Verification
The assertions watch several rules on every cycle:
- the reset values;
- that an idle edge holds the result and flags;
- that a range request only ever appears together with the overflow flag and after an enabled, accepted operation;
- that both register forms produce the right sums, with or without the stored carry.

Only the directed scenarios can show the exact flag pairs at the signed and unsigned boundaries, and the cases where a carry-in creates or removes overflow. They also cover sign extension of the immediate and that a pulse lasts a single cycle.

// File: rtl/add_flag_unit.sv
module add_flag_unit #(
  parameter int DW = 32,
  parameter int IW = 16
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          valid_i,
  input  logic [1:0]    op_i,
  input  logic [DW-1:0] opa_i,
  input  logic [DW-1:0] opb_i,
  input  logic [IW-1:0] imm_i,
  input  logic          ovf_exc_en_i,
  output logic [DW-1:0] result_o,
  output logic          carry_o,
  output logic          ovf_o,
  output logic          range_exc_o
);

  localparam int EXT = DW - IW;

  logic [DW-1:0] rhs;
  logic          cin;
  logic [DW:0]   full;
  logic          sovf;

  assign rhs  = op_i[1] ? {{EXT{imm_i[IW-1]}}, imm_i} : opb_i;
  assign cin  = op_i[0] & carry_o;
  assign full = {1'b0, opa_i} + {1'b0, rhs} + {{DW{1'b0}}, cin};
  assign sovf = (opa_i[DW-1] == rhs[DW-1]) && (full[DW-1] != opa_i[DW-1]);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      result_o    <= '0;
      carry_o     <= 1'b0;
      ovf_o       <= 1'b0;
      range_exc_o <= 1'b0;
    end else begin
      range_exc_o <= valid_i & ovf_exc_en_i & sovf;
      if (valid_i) begin
        result_o <= full[DW-1:0];
        carry_o  <= full[DW];
        ovf_o    <= sovf;
      end
    end
  end

  assert_reset_clears_R1: assert property (@(posedge clk_i)
    rst_i |=> (result_o == '0 && !carry_o && !ovf_o && !range_exc_o));

  assert_plain_reg_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    (valid_i && op_i == 2'b00) |=> result_o == $past(opa_i + opb_i));

  assert_carry_reg_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    (valid_i && op_i == 2'b01) |=>
      result_o == $past(opa_i + opb_i + {{(DW-1){1'b0}}, carry_o}));

  assert_exc_with_ovf_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    range_exc_o |-> ovf_o);

  assert_exc_enabled_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    range_exc_o |-> ($past(valid_i) && $past(ovf_exc_en_i)));

  assert_idle_hold_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    !valid_i |=> ($stable(result_o) && $stable(carry_o) && $stable(ovf_o) && !range_exc_o));

endmodule

// File: tb/test_add_flag_unit.sv
module test_add_flag_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [31:0] opa = '0, opb = '0;
  logic [15:0] imm = '0;
  logic        en = 1'b0;
  logic [31:0] result;
  logic        carry, ovf, exc;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  add_flag_unit i_add_flag_unit (
    .clk_i(clk), .rst_i(rst), .valid_i(valid), .op_i(op),
    .opa_i(opa), .opb_i(opb), .imm_i(imm), .ovf_exc_en_i(en),
    .result_o(result), .carry_o(carry), .ovf_o(ovf), .range_exc_o(exc)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // Issue one accepted operation, then check the registered outputs one edge later.
  task automatic run_op(input string tag, input logic [1:0] o, input logic [31:0] a,
                        input logic [31:0] b, input logic [15:0] im, input logic e,
                        input logic [31:0] er, input logic ec, input logic eo, input logic ex);
    @(negedge clk);
    valid = 1'b1; op = o; opa = a; opb = b; imm = im; en = e;
    @(negedge clk);
    valid = 1'b0;
    check({tag, " result"}, result, er);
    check({tag, " carry"}, {31'b0, carry}, {31'b0, ec});
    check({tag, " ovf"}, {31'b0, ovf}, {31'b0, eo});
    check({tag, " exc"}, {31'b0, exc}, {31'b0, ex});
  endtask

  task automatic preset_carry(input logic c);
    if (c) run_op("preset c1", 2'b00, 32'hffffffff, 32'h1, 16'h0, 1'b0, 32'h0, 1'b1, 1'b0, 1'b0);
    else   run_op("preset c0", 2'b00, 32'h1, 32'h1, 16'h0, 1'b0, 32'h2, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_reset;
    check("R1 result", result, 32'h0);
    check("R1 carry", {31'b0, carry}, 32'h0);
    check("R1 ovf", {31'b0, ovf}, 32'h0);
    check("R1 exc", {31'b0, exc}, 32'h0);
  endtask

  task automatic t_plain_reg;
    preset_carry(1'b0);
    run_op("R2 small", 2'b00, 32'h1, 32'h2, 16'h0, 1'b0, 32'h3, 1'b0, 1'b0, 1'b0);
    preset_carry(1'b1);
    run_op("R2 carry ignored", 2'b00, 32'h1, 32'h2, 16'h0, 1'b0, 32'h3, 1'b0, 1'b0, 1'b0);
    run_op("R6 neg carry", 2'b00, 32'hffffffff, 32'hfffffffe, 16'h0, 1'b0, 32'hfffffffd, 1'b1, 1'b0, 1'b0);
    run_op("R7 pos no flags", 2'b00, 32'h40000000, 32'h3fffffff, 16'h0, 1'b0, 32'h7fffffff, 1'b0, 1'b0, 1'b0);
    run_op("R7 pos ovf", 2'b00, 32'h40000000, 32'h40000000, 16'h0, 1'b0, 32'h80000000, 1'b0, 1'b1, 1'b0);
    run_op("R6 neg carry only", 2'b00, 32'hc0000000, 32'hc0000000, 16'h0, 1'b0, 32'h80000000, 1'b1, 1'b0, 1'b0);
    run_op("R7 both flags", 2'b00, 32'hbfffffff, 32'hbfffffff, 16'h0, 1'b0, 32'h7ffffffe, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_carry_reg;
    preset_carry(1'b1);
    run_op("R3 cin makes ovf", 2'b01, 32'h40000000, 32'h3fffffff, 16'h0, 1'b0, 32'h80000000, 1'b0, 1'b1, 1'b0);
    preset_carry(1'b1);
    run_op("R6 max+0+c", 2'b01, 32'hffffffff, 32'h0, 16'h0, 1'b0, 32'h0, 1'b1, 1'b0, 1'b0);
    run_op("R6 0+max+c", 2'b01, 32'h0, 32'hffffffff, 16'h0, 1'b0, 32'h0, 1'b1, 1'b0, 1'b0);
    run_op("R7 cin avoids ovf", 2'b01, 32'hc0000000, 32'hbfffffff, 16'h0, 1'b0, 32'h80000000, 1'b1, 1'b0, 1'b0);
    preset_carry(1'b0);
    run_op("R3 no cin", 2'b01, 32'h40000000, 32'h3fffffff, 16'h0, 1'b0, 32'h7fffffff, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_imm;
    preset_carry(1'b1);
    run_op("R4 carry ignored", 2'b10, 32'h1, 32'h0, 16'h0002, 1'b0, 32'h3, 1'b0, 1'b0, 1'b0);
    run_op("R4 sext fffe", 2'b10, 32'hffffffff, 32'h0, 16'hfffe, 1'b0, 32'hfffffffd, 1'b1, 1'b0, 1'b0);
    run_op("R4 sext 8000", 2'b10, 32'h80008000, 32'h0, 16'h8000, 1'b0, 32'h80000000, 1'b1, 1'b0, 1'b0);
    run_op("R4 pos ovf", 2'b10, 32'h7fffc000, 32'h0, 16'h4000, 1'b0, 32'h80000000, 1'b0, 1'b1, 1'b0);
    run_op("R4 both flags", 2'b10, 32'h80007fff, 32'h0, 16'h8000, 1'b0, 32'h7fffffff, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_imm_carry;
    preset_carry(1'b1);
    run_op("R5 cin makes ovf", 2'b11, 32'h7fff8000, 32'h0, 16'h7fff, 1'b0, 32'h80000000, 1'b0, 1'b1, 1'b0);
    preset_carry(1'b1);
    run_op("R5 0+ffff+c", 2'b11, 32'h0, 32'h0, 16'hffff, 1'b0, 32'h0, 1'b1, 1'b0, 1'b0);
    run_op("R5 cin avoids ovf", 2'b11, 32'h80007fff, 32'h0, 16'h8000, 1'b0, 32'h80000000, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_exc;
    run_op("R8 ovf raises", 2'b00, 32'h40000000, 32'h40000000, 16'h0, 1'b1, 32'h80000000, 1'b0, 1'b1, 1'b1);
    @(negedge clk);
    check("R8 single pulse", {31'b0, exc}, 32'h0);
    run_op("R8 carry alone", 2'b00, 32'hffffffff, 32'hfffffffe, 16'h0, 1'b1, 32'hfffffffd, 1'b1, 1'b0, 1'b0);
    run_op("R8 cin caused ovf", 2'b11, 32'h7fffc000, 32'h0, 16'h3fff, 1'b1, 32'h80000000, 1'b0, 1'b1, 1'b1);
    run_op("R8 both flags", 2'b00, 32'hbfffffff, 32'hbfffffff, 16'h0, 1'b1, 32'h7ffffffe, 1'b1, 1'b1, 1'b1);
    run_op("R9 disabled", 2'b00, 32'hbfffffff, 32'hbfffffff, 16'h0, 1'b0, 32'h7ffffffe, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_hold;
    @(negedge clk);
    valid = 1'b0; op = 2'b01; opa = 32'h12345678; opb = 32'h11111111; en = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 result held", result, 32'h7ffffffe);
    check("R10 carry held", {31'b0, carry}, 32'h1);
    check("R10 ovf held", {31'b0, ovf}, 32'h1);
    check("R10 no exc", {31'b0, exc}, 32'h0);
  endtask

  task automatic t_replace;
    run_op("R11 flags cleared", 2'b00, 32'h1, 32'h2, 16'h0, 1'b1, 32'h3, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_plain_reg();
    t_carry_reg();
    t_imm();
    t_imm_carry();
    t_exc();
    t_hold();
    t_replace();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end
endmodule